// File: doc/BRIEF.md
# Switch Reset Initialization Sequencer

This block brings a multi-port switch out of fundamental reset in a fixed order. An active-low reset input is synchronized inside the block. The halt strap of the boot vector is captured while reset is released. The block then holds the PLL in reset until the clock is reported stable, and waits for PLL lock. After lock it raises a level request to an external configuration loader and waits for that loader to report done, with or without error. A programmable cycle timeout bounds the wait so that the load phase stays within its time budget, which is typically set to about 200 ms worth of cycles.

When the load ends, the ports are either released at once or kept in a quasi-reset hold. They are kept in hold while the halt control bit is set. The halt bit can be preset by the strap, forced by a load error, or forced by a timeout. Software clears the bit through a small write interface, and that releases the hold. On the way to normal operation the block always passes through one state that clears the register-unlock control bit. The port holds drop only after that state.

There are six states, with these codes: BOOT (0), LOCKWAIT (1), CFGLOAD (2), HOLD (3), RELOCK (4) and RUN (5). The transitions are:
- BOOT→LOCKWAIT when the clock is stable.
- LOCKWAIT→CFGLOAD on lock.
- CFGLOAD→HOLD when the load ends and the halt bit is set. A load error or a timeout always sets the halt bit.
- CFGLOAD→RELOCK when the load ends cleanly and the halt bit is clear.
- HOLD→RELOCK once the halt bit reads zero.
- RELOCK→RUN unconditionally.
- Any state→BOOT on reset.

Top module: `swinit_seq`

## Requirements
- R1: While reset is asserted, and immediately on a new reset assertion from any state, the outputs take their defaults: state code 0, every port hold high, PLL reset high, load request low, halt 0, unlock 1, done 0, fail 0.
- R2: PLL reset stays high in BOOT until clock-stable is high. The load request rises only after PLL lock has been seen in LOCKWAIT.
- R3: The halt bit takes the value of the halt strap sampled at reset release. The value is visible from LOCKWAIT on.
- R4: A load completion sets the done status bit. If the completion carries an error, the fail status bit and the halt bit are also set.
- R5: With a timeout limit N≠0, a load that never completes leaves CFGLOAD after exactly N cycles into HOLD. In that case fail and halt are set and done stays 0. A limit of 0 disables the timeout.
- R6: In HOLD every port hold stays high until software writes the halt bit to 0. The following cycle the state is RELOCK.
- R7: If the halt bit is clear when the load completes, the state goes straight to RELOCK. This also applies when software cleared the strap-preset bit during CFGLOAD.
- R8: RELOCK lasts one cycle and clears the unlock bit on entry to RUN. Port holds are low only in RUN.
- R9: Software writes of the halt bit are ignored in BOOT, RELOCK and RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| arst_n | input | 1 | Asynchronous active-low fundamental reset |
| boot_halt_strap | input | 1 | Halt strap of the boot vector |
| clk_stable | input | 1 | Reference clock stable indication |
| pll_lock | input | 1 | PLL lock indication |
| pll_rst | output | 1 | PLL reset, high in BOOT |
| ld_req | output | 1 | Configuration loader request, high in CFGLOAD |
| ld_done | input | 1 | Loader completion pulse |
| ld_err | input | 1 | Loader error, qualified by ld_done |
| ld_timeout_cycles | input | TMO_W | Load timeout in cycles, 0 disables |
| ctl_wr_en | input | 1 | Software write strobe for the halt bit |
| ctl_wr_halt | input | 1 | Halt bit write data |
| ctl_halt | output | 1 | Halt control bit |
| ctl_unlock | output | 1 | Register-unlock control bit |
| stat_ld_done | output | 1 | Load-done status bit |
| stat_ld_fail | output | 1 | Load error or timeout status bit |
| port_qrst | output | NPORTS | Per-port quasi-reset hold |
| seq_state | output | 3 | Current state code for debug |

## Verification
The assertions assume that ld_done arrives only as a single-cycle pulse while the load request is high. They also assume that the strap stays steady around reset release, and that PLL lock is never reported before the clock is stable. The stimulus respects these limits. It drives each loader completion for exactly one cycle, and only after the request is seen high. It sets the strap before reset is released and does not change it until the next reset. It raises lock only after the state has reached LOCKWAIT. All inputs change on the falling clock edge, away from the edge at which the block samples them.

// File: rtl/swinit_pkg.sv
package swinit_pkg;

    typedef enum logic [2:0] {
        ST_BOOT     = 3'd0,
        ST_LOCKWAIT = 3'd1,
        ST_CFGLOAD  = 3'd2,
        ST_HOLD     = 3'd3,
        ST_RELOCK   = 3'd4,
        ST_RUN      = 3'd5
    } seq_state_e;

endpackage

// File: rtl/swinit_rstsync.sv
module swinit_rstsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_o
);
    logic [STAGES-1:0] chain;

    // asynchronous assertion, synchronous release
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '1;
        else         chain <= {chain[STAGES-2:0], 1'b0};
    end

    assign rst_o = chain[STAGES-1];
endmodule

// File: rtl/swinit_ldtimer.sv
module swinit_ldtimer #(
    parameter int TMO_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)       cnt <= '0;
        else if (!run) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // limit of zero disables the timeout
    assign expired = run && (limit != '0) && (cnt == limit - 1'b1);
endmodule

// File: rtl/swinit_fsm.sv
module swinit_fsm
    import swinit_pkg::*;
#(
    parameter int NPORTS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_halt,
    input  logic              clk_stable,
    input  logic              pll_lock,
    input  logic              ld_done,
    input  logic              ld_err,
    input  logic              ld_expired,
    input  logic              wr_en,
    input  logic              wr_halt,
    output seq_state_e        state,
    output logic              pll_rst,
    output logic              ld_req,
    output logic              halt,
    output logic              unlock,
    output logic              done,
    output logic              fail,
    output logic [NPORTS-1:0] port_hold
);
    seq_state_e state_nxt;
    logic       strap_q;
    logic       wr_ok, load_fin, load_bad, halt_nxt, hold_all;

    // strap captured every cycle while synchronized reset is held
    always_ff @(posedge clk) begin
        if (rst) strap_q <= boot_halt;
    end

    always_comb begin
        wr_ok    = wr_en && (state == ST_LOCKWAIT || state == ST_CFGLOAD || state == ST_HOLD);
        load_fin = (state == ST_CFGLOAD) && ld_done;
        load_bad = (load_fin && ld_err) || ((state == ST_CFGLOAD) && !ld_done && ld_expired);
        if (state == ST_BOOT) halt_nxt = strap_q;
        else if (load_bad)    halt_nxt = 1'b1;
        else if (wr_ok)       halt_nxt = wr_halt;
        else                  halt_nxt = halt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_BOOT:     if (clk_stable) state_nxt = ST_LOCKWAIT;
            ST_LOCKWAIT: if (pll_lock)   state_nxt = ST_CFGLOAD;
            ST_CFGLOAD: begin
                if (load_fin || load_bad)
                    state_nxt = halt_nxt ? ST_HOLD : ST_RELOCK;
            end
            ST_HOLD:     if (!halt)      state_nxt = ST_RELOCK;
            ST_RELOCK:   state_nxt = ST_RUN;
            ST_RUN:      state_nxt = ST_RUN;
            default:     state_nxt = ST_BOOT;
        endcase
    end

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_BOOT;
        else     state <= state_nxt;
    end

    // control and status bits
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            halt   <= 1'b0;
            unlock <= 1'b1;
            done   <= 1'b0;
            fail   <= 1'b0;
        end else begin
            halt <= halt_nxt;
            if (state == ST_RELOCK) unlock <= 1'b0;
            if (load_fin)           done   <= 1'b1;
            if (load_bad)           fail   <= 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        pll_rst  = (state == ST_BOOT);
        ld_req   = (state == ST_CFGLOAD);
        hold_all = (state != ST_RUN);
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign port_hold[p] = hold_all;
    end
endmodule

// File: rtl/swinit_seq.sv
module swinit_seq
    import swinit_pkg::*;
#(
    parameter int NPORTS     = 8,
    parameter int TMO_W      = 26,
    parameter int SYNC_STAGE = 2
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              boot_halt_strap,
    input  logic              clk_stable,
    input  logic              pll_lock,
    output logic              pll_rst,
    output logic              ld_req,
    input  logic              ld_done,
    input  logic              ld_err,
    input  logic [TMO_W-1:0]  ld_timeout_cycles,
    input  logic              ctl_wr_en,
    input  logic              ctl_wr_halt,
    output logic              ctl_halt,
    output logic              ctl_unlock,
    output logic              stat_ld_done,
    output logic              stat_ld_fail,
    output logic [NPORTS-1:0] port_qrst,
    output logic [2:0]        seq_state
);
    logic       rst_s;
    logic       expired;
    seq_state_e st;

    swinit_rstsync #(.STAGES(SYNC_STAGE)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .rst_o  (rst_s)
    );

    swinit_ldtimer #(.TMO_W(TMO_W)) u_tmr (
        .clk     (clk),
        .rst     (rst_s),
        .run     (ld_req),
        .limit   (ld_timeout_cycles),
        .expired (expired)
    );

    swinit_fsm #(.NPORTS(NPORTS)) u_fsm (
        .clk        (clk),
        .rst        (rst_s),
        .boot_halt  (boot_halt_strap),
        .clk_stable (clk_stable),
        .pll_lock   (pll_lock),
        .ld_done    (ld_done),
        .ld_err     (ld_err),
        .ld_expired (expired),
        .wr_en      (ctl_wr_en),
        .wr_halt    (ctl_wr_halt),
        .state      (st),
        .pll_rst    (pll_rst),
        .ld_req     (ld_req),
        .halt       (ctl_halt),
        .unlock     (ctl_unlock),
        .done       (stat_ld_done),
        .fail       (stat_ld_fail),
        .port_hold  (port_qrst)
    );

    assign seq_state = st;
endmodule

// File: rtl/swinit_chk.sv
module swinit_chk #(
    parameter int NPORTS = 8
) (
    input logic              clk,
    input logic              arst_n,
    input logic [2:0]        seq_state,
    input logic              pll_rst,
    input logic              ld_req,
    input logic              ctl_halt,
    input logic              ctl_unlock,
    input logic              stat_ld_done,
    input logic              stat_ld_fail,
    input logic [NPORTS-1:0] port_qrst
);
    // R2
    req_after_pll_chk: assert property (@(posedge clk) disable iff (!arst_n)
        ld_req |-> !pll_rst);

    // R4
    done_from_req_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(stat_ld_done) |-> $past(ld_req));

    // R5
    fail_sets_halt_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(stat_ld_fail) |-> ctl_halt);

    // R6
    halt_holds_ports_chk: assert property (@(posedge clk) disable iff (!arst_n)
        ctl_halt |-> (port_qrst == {NPORTS{1'b1}}));

    // R8
    relock_one_cycle_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (seq_state == 3'd4) |=> (seq_state == 3'd5));

    // R8
    run_locked_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (seq_state == 3'd5) |-> !ctl_unlock);

    // R8
    ports_free_only_in_run_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (port_qrst != {NPORTS{1'b1}}) |-> (seq_state == 3'd5));
endmodule

bind swinit_seq swinit_chk #(.NPORTS(NPORTS)) u_chk (
    .clk          (clk),
    .arst_n       (arst_n),
    .seq_state    (seq_state),
    .pll_rst      (pll_rst),
    .ld_req       (ld_req),
    .ctl_halt     (ctl_halt),
    .ctl_unlock   (ctl_unlock),
    .stat_ld_done (stat_ld_done),
    .stat_ld_fail (stat_ld_fail),
    .port_qrst    (port_qrst)
);

// File: tb/test_swinit_seq.sv
`timescale 1ns/1ps
module test_swinit_seq;
    localparam int NP = 8;
    localparam int TW = 26;
    localparam logic [NP-1:0] ALL1 = '1;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic strap = 1'b0, clk_stable = 1'b0, pll_lock = 1'b0;
    logic ld_done = 1'b0, ld_err = 1'b0, wr_en = 1'b0, wr_halt = 1'b0;
    logic [TW-1:0] tmo = '0;
    logic pll_rst, ld_req, ctl_halt, ctl_unlock, st_done, st_fail;
    logic [NP-1:0] qrst;
    logic [2:0] state;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    swinit_seq #(.NPORTS(NP), .TMO_W(TW)) i_swinit_seq (
        .clk(clk), .arst_n(arst_n), .boot_halt_strap(strap),
        .clk_stable(clk_stable), .pll_lock(pll_lock), .pll_rst(pll_rst),
        .ld_req(ld_req), .ld_done(ld_done), .ld_err(ld_err),
        .ld_timeout_cycles(tmo), .ctl_wr_en(wr_en), .ctl_wr_halt(wr_halt),
        .ctl_halt(ctl_halt), .ctl_unlock(ctl_unlock), .stat_ld_done(st_done),
        .stat_ld_fail(st_fail), .port_qrst(qrst), .seq_state(state)
    );

    // vector fields: {strap, loader error, use timeout, expected halt after load}
    localparam logic [3:0] VEC [4] = '{4'b0000, 4'b1001, 4'b0101, 4'b0011};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_defaults(input string req);
        chk(req, state, 0);
        chk(req, qrst, ALL1);
        chk(req, pll_rst, 1);
        chk(req, ld_req, 0);
        chk(req, ctl_halt, 0);
        chk(req, ctl_unlock, 1);
        chk(req, st_done, 0);
        chk(req, st_fail, 0);
    endtask

    // reset, release, reach CFGLOAD with the given strap
    task automatic boot_to_load(input logic s);
        arst_n = 1'b0; clk_stable = 0; pll_lock = 0; ld_done = 0; ld_err = 0; wr_en = 0;
        strap = s;
        repeat (3) @(negedge clk);
        check_defaults("R1");
        arst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 pll reset held in BOOT", {state, pll_rst}, {3'd0, 1'b1});
        clk_stable = 1'b1;
        @(negedge clk);
        chk("R2 LOCKWAIT", {state, pll_rst, ld_req}, {3'd1, 1'b0, 1'b0});
        chk("R3 strap to halt", ctl_halt, s);
        repeat (3) @(negedge clk);
        chk("R2 no request before lock", {state, ld_req}, {3'd1, 1'b0});
        pll_lock = 1'b1;
        @(negedge clk);
        chk("R2 request after lock", {state, ld_req}, {3'd2, 1'b1});
    endtask

    task automatic finish_run();
        chk("R8 RELOCK", {state, ctl_unlock, qrst}, {3'd4, 1'b1, ALL1});
        @(negedge clk);
        chk("R8 RUN", {state, ctl_unlock, qrst}, {3'd5, 1'b0, {NP{1'b0}}});
        wr_en = 1'b1; wr_halt = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 write ignored in RUN", {ctl_halt, qrst}, {1'b0, {NP{1'b0}}});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        for (int v = 0; v < 4; v++) begin
            boot_to_load(VEC[v][3]);
            if (VEC[v][1]) begin
                // R5 timeout after exactly 5 cycles in CFGLOAD
                tmo = 5;
                repeat (4) @(negedge clk);
                chk("R5 still loading", state, 2);
                @(negedge clk);
                chk("R5 timeout to HOLD", {state, st_fail, ctl_halt, st_done}, {3'd3, 1'b1, 1'b1, 1'b0});
            end else begin
                tmo = 0;
                repeat (20) @(negedge clk);
                chk("R5 limit zero disables", state, 2);
                ld_done = 1'b1; ld_err = VEC[v][2];
                @(negedge clk);
                ld_done = 1'b0; ld_err = 1'b0;
                chk("R4 done status", st_done, 1);
                chk("R4 fail status", st_fail, VEC[v][2]);
                chk("R4 halt bit", ctl_halt, VEC[v][0]);
            end
            if (VEC[v][0]) begin
                repeat (3) @(negedge clk);
                chk("R6 held in HOLD", {state, qrst, ctl_unlock}, {3'd3, ALL1, 1'b1});
                wr_en = 1'b1; wr_halt = 1'b0;
                @(negedge clk);
                wr_en = 1'b0;
                chk("R6 halt cleared", {state, ctl_halt}, {3'd3, 1'b0});
                @(negedge clk);
            end else begin
                chk("R7 direct to RELOCK", state, 4);
            end
            finish_run();
        end

        // R7 software clears the strap-preset halt during CFGLOAD
        tmo = 0;
        boot_to_load(1'b1);
        wr_en = 1'b1; wr_halt = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 halt cleared in load", ctl_halt, 0);
        ld_done = 1'b1;
        @(negedge clk);
        ld_done = 1'b0;
        chk("R7 no halt at completion", state, 4);
        finish_run();

        // R9 write in BOOT ignored
        arst_n = 1'b0; clk_stable = 0; pll_lock = 0; strap = 0;
        repeat (2) @(negedge clk);
        arst_n = 1'b1;
        repeat (3) @(negedge clk);
        wr_en = 1'b1; wr_halt = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 write ignored in BOOT", {state, ctl_halt}, {3'd0, 1'b0});
        clk_stable = 1'b1;
        @(negedge clk);
        chk("R9 halt still clear", ctl_halt, 0);

        // R1 reset from HOLD restores defaults at once
        boot_to_load(1'b1);
        ld_done = 1'b1;
        @(negedge clk);
        ld_done = 1'b0;
        chk("R1 in HOLD before reset", state, 3);
        arst_n = 1'b0;
        #1;
        check_defaults("R1 reset from HOLD");
        @(negedge clk);
        check_defaults("R1 reset held");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule